// File: doc/BRIEF.md
# Event-Driven Pulse Capture Unit

This block sits next to a free-running counter and turns one event line into timing measurements. The event line is first conditioned: an invert control can flip its polarity, and an enable can force it inactive. After conditioning, a rising transition is the *active edge* and a falling transition is the *opposite edge*. A 3-bit action code selects what those edges do. The code can take a timestamp, measure period and pulse width together (with either channel assignment), measure pulse width only, or do nothing.

Two capture channels hold the results. Each channel has its own enable, its own capture rule and its own flag. The capture rule can store every value, keep the running minimum, or keep the running maximum. A shared error flag reports an overrun, which is a store into a channel whose flag was still set. Software clears the flags by pulsing a write-one-to-clear vector.

A small state machine tracks measurement modes. Its states are `ST_SYNC`, `ST_PULSE` and `ST_GAP`:

- `ST_SYNC` waits for the first active edge after reset or after entering a measurement mode. On that edge the counter restarts and the machine moves to `ST_PULSE`.
- `ST_PULSE` lasts while the event is active. On the opposite edge the width is captured and the machine moves to `ST_GAP`.
- `ST_GAP` lasts while the event is inactive. On the next active edge the counter restarts, the period is captured (except in width-only mode) and the machine returns to `ST_PULSE`.
- Any action code that is not a measurement mode forces the machine back to `ST_SYNC`.

Top module: `pulse_capture_unit`

## Requirements
- R1: While reset is held, the count, both capture values, both channel flags and the error flag are all 0.
- R2: The conditioned level is (event input XOR invert) AND enable. With enable low, no edge is seen and nothing is captured.
- R3: Action code 4 (timestamp) stores the current count into channel 0 on every active edge. The counter is never restarted in this mode, so two stamps differ by the number of clock cycles between their edges.
- R4: Action code 5 stores the period into channel 0 and the width into channel 1. The counter reloads to 1 on each active edge. As a result, a level active for N sampled cycles yields a width of N, and active edges M cycles apart yield a period of M.
- R5: Action code 6 is the same as code 5 with the channels swapped: period into channel 1, width into channel 0.
- R6: Action code 7 stores the width into channel 0 and never writes channel 1.
- R7: Action codes 0 to 3 capture nothing. After entering a measurement mode, the first active edge only restarts the counter and stores no period.
- R8: A channel whose enable bit is 0 (bit 0 for channel 0, bit 1 for channel 1) keeps its value and does not raise its flag.
- R9: Each channel's rule code works as follows. Code 0 stores always. Code 1 stores only a value below the held one. Code 2 stores only a value above the held one. Code 3 acts as code 0. The first store after reset ignores the rule.
- R10: A store raises that channel's flag. A store while that flag is already set still overwrites the value and also sets the error flag. A set takes priority over a clear in the same cycle.
- R11: A 1 on the clear vector clears one flag per bit: bit 0 clears channel 0, bit 1 clears channel 1, and bit 2 clears the error flag. Each bit clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Event line, synchronous to clk |
| evt_inv | input | 1 | Invert event polarity |
| evt_en | input | 1 | Event enable; 0 forces the conditioned level low |
| action_i | input | 3 | Event action code (0..7) |
| cap_en_i | input | 2 | Per-channel capture enable |
| rule0_i | input | 2 | Capture rule, channel 0 |
| rule1_i | input | 2 | Capture rule, channel 1 |
| flag_clr_i | input | 3 | Write-one-to-clear: ch0, ch1, error |
| count_o | output | CNT_W | Counter value |
| cap0_o | output | CNT_W | Channel 0 held value |
| cap1_o | output | CNT_W | Channel 1 held value |
| cap_flag_o | output | 2 | Channel capture flags |
| err_flag_o | output | 1 | Overrun error flag |

## Verification
Each result appears right after the first rising clock edge that samples the changed event level. On that edge the count reloads to 1, the capture value is written and the flag and error bits are set. The value captured is the count held just before that edge. A clear takes effect on the edge that samples it. The bench changes inputs on falling edges and reads outputs one falling edge after the edge that must update them. Every expected width, period or stamp difference is therefore the number of falling edges the bench waited between level changes.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [2:0] {
        ACT_OFF    = 3'd0,
        ACT_RETRIG = 3'd1,
        ACT_COUNT  = 3'd2,
        ACT_START  = 3'd3,
        ACT_STAMP  = 3'd4,
        ACT_PER_W  = 3'd5,
        ACT_W_PER  = 3'd6,
        ACT_WIDTH  = 3'd7
    } evt_action_e;

    typedef enum logic [1:0] {
        RULE_ANY  = 2'd0,
        RULE_MIN  = 2'd1,
        RULE_MAX  = 2'd2,
        RULE_RSVD = 2'd3
    } cap_rule_e;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } meas_state_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/pcap_edge_detect.sv
module pcap_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic inv_i,
    input  logic en_i,
    output logic act_o,
    output logic opp_o
);
    logic lvl;
    logic lvl_q;

    assign lvl = (evt_i ^ inv_i) & en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign act_o = lvl & ~lvl_q;
    assign opp_o = ~lvl & lvl_q;

    // R2: a gated input leaves the stored level low, so no falling edge follows
    a_r2_gate_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !opp_o || en_i);
endmodule

// File: rtl/pcap_seq.sv
module pcap_seq
    import pcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_edge_i,
    input  logic              opp_edge_i,
    input  logic [2:0]        action_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CH-1:0] strobe_o
);
    localparam logic [CNT_W-1:0] RELOAD = {{(CNT_W-1){1'b0}}, 1'b1};

    evt_action_e act;
    meas_state_e state_q, state_d;
    logic        measuring;
    logic        restart;
    logic        per_stb;
    logic        wid_stb;
    logic [CNT_W-1:0] cnt_q;

    assign act       = evt_action_e'(action_i);
    assign measuring = (act == ACT_PER_W) || (act == ACT_W_PER) || (act == ACT_WIDTH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!measuring) begin
            state_d = ST_SYNC;
        end else begin
            unique case (state_q)
                ST_SYNC:  if (act_edge_i) state_d = ST_PULSE;
                ST_PULSE: if (opp_edge_i) state_d = ST_GAP;
                ST_GAP:   if (act_edge_i) state_d = ST_PULSE;
                default:  state_d = ST_SYNC;
            endcase
        end
    end

    // outputs
    always_comb begin
        restart  = measuring && act_edge_i;
        per_stb  = measuring && act_edge_i && (state_q == ST_GAP);
        wid_stb  = measuring && opp_edge_i && (state_q == ST_PULSE);
        strobe_o = '0;
        unique case (act)
            ACT_STAMP: strobe_o[0] = act_edge_i;
            ACT_PER_W: begin
                strobe_o[0] = per_stb;
                strobe_o[1] = wid_stb;
            end
            ACT_W_PER: begin
                strobe_o[1] = per_stb;
                strobe_o[0] = wid_stb;
            end
            ACT_WIDTH: strobe_o[0] = wid_stb;
            ACT_OFF, ACT_RETRIG, ACT_COUNT, ACT_START: strobe_o = '0;
            default: strobe_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= RELOAD;
        else              cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    // R4: an active edge in a measurement mode reloads the counter to 1
    a_r4_reload_one: assert property (@(posedge clk) disable iff (!rst_n)
        (measuring && act_edge_i) |=> cnt_q == RELOAD);
    // R3: timestamp mode never disturbs the free-running count
    a_r3_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STAMP) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R7: leaving the measurement modes returns the machine to sync
    a_r7_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !measuring |=> state_q == ST_SYNC);
    // R4: the opposite edge during a pulse ends it in the gap state
    a_r4_pulse_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (measuring && state_q == ST_PULSE && opp_edge_i) |=> state_q == ST_GAP);
endmodule

// File: rtl/pcap_channel.sv
module pcap_channel
    import pcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] value_i,
    input  logic             en_i,
    input  logic [1:0]       rule_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] held_o,
    output logic             flag_o,
    output logic             overrun_o
);
    cap_rule_e        rule;
    logic             valid_q;
    logic             flag_q;
    logic             pass;
    logic             store;
    logic [CNT_W-1:0] held_q;

    assign rule = cap_rule_e'(rule_i);

    always_comb begin
        unique case (rule)
            RULE_MIN: pass = value_i < held_q;
            RULE_MAX: pass = value_i > held_q;
            RULE_ANY, RULE_RSVD: pass = 1'b1;
            default:  pass = 1'b1;
        endcase
    end

    assign store     = en_i && strobe_i && (!valid_q || pass);
    assign overrun_o = store && flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            valid_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (store) begin
                held_q  <= value_i;
                valid_q <= 1'b1;
            end
            if (store)      flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign held_o = held_q;
    assign flag_o = flag_q;

    // R8: a disabled channel keeps its value
    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> held_q == $past(held_q));
    // R9: minimum tracking never grows once a value is held
    a_r9_min_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && rule == RULE_MIN) |=> held_q <= $past(held_q));
    // R9: maximum tracking never shrinks once a value is held
    a_r9_max_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && rule == RULE_MAX) |=> held_q >= $past(held_q));
    // R10: a store raises the flag and holds the offered value
    a_r10_flag_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> flag_q && held_q == $past(value_i));
    // R11: a clear without a strobe drops the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !strobe_i) |=> !flag_q);
endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit
    import pcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             evt_inv,
    input  logic             evt_en,
    input  logic [2:0]       action_i,
    input  logic [1:0]       cap_en_i,
    input  logic [1:0]       rule0_i,
    input  logic [1:0]       rule1_i,
    input  logic [2:0]       flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cap0_o,
    output logic [CNT_W-1:0] cap1_o,
    output logic [1:0]       cap_flag_o,
    output logic             err_flag_o
);
    logic             act_edge, opp_edge;
    logic [NUM_CH-1:0] strobe;
    logic [NUM_CH-1:0] overrun;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] held [NUM_CH];
    logic [1:0]       rules [NUM_CH];
    logic             err_q;

    assign rules[0] = rule0_i;
    assign rules[1] = rule1_i;

    pcap_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_in),
        .inv_i (evt_inv),
        .en_i  (evt_en),
        .act_o (act_edge),
        .opp_o (opp_edge)
    );

    pcap_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_edge_i (act_edge),
        .opp_edge_i (opp_edge),
        .action_i   (action_i),
        .count_o    (cnt),
        .strobe_o   (strobe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pcap_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_i  (strobe[c]),
            .value_i   (cnt),
            .en_i      (cap_en_i[c]),
            .rule_i    (rules[c]),
            .clr_i     (flag_clr_i[c]),
            .held_o    (held[c]),
            .flag_o    (cap_flag_o[c]),
            .overrun_o (overrun[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             err_q <= 1'b0;
        else if (|overrun)      err_q <= 1'b1;
        else if (flag_clr_i[2]) err_q <= 1'b0;
    end

    assign count_o    = cnt;
    assign cap0_o     = held[0];
    assign cap1_o     = held[1];
    assign err_flag_o = err_q;

    // R10: an overrun always leaves the error flag set
    a_r10_err_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (|overrun) |=> err_flag_o);
    // R11: without a clear bit the error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag_o && !flag_clr_i[2]) |=> err_flag_o);
    // R6: width-only mode never changes channel 1
    a_r6_ch1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (action_i == 3'd7) |=> $stable(cap1_o));
endmodule

// File: tb/pulse_capture_unit_tb_top.sv
module pulse_capture_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic evt_in, evt_inv, evt_en;
    logic [2:0] action;
    logic [1:0] cap_en, rule0, rule1;
    logic [2:0] flag_clr;
    logic [CNT_W-1:0] count, cap0, cap1;
    logic [1:0] cap_flag;
    logic err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_capture_unit #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_inv(evt_inv),
        .evt_en(evt_en), .action_i(action), .cap_en_i(cap_en),
        .rule0_i(rule0), .rule1_i(rule1), .flag_clr_i(flag_clr),
        .count_o(count), .cap0_o(cap0), .cap1_o(cap1),
        .cap_flag_o(cap_flag), .err_flag_o(err_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; evt_in = 1'b0; evt_inv = 1'b0; evt_en = 1'b1;
        action = 3'd0; cap_en = 2'b11; rule0 = 2'd0; rule1 = 2'd0;
        flag_clr = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // active for h sampled cycles, then inactive for l
    task automatic pulse(input int h, input int l);
        evt_in = ~evt_inv;
        repeat (h) @(negedge clk);
        evt_in = evt_inv;
        repeat (l) @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] bits);
        flag_clr = bits;
        @(negedge clk);
        flag_clr = 3'b000;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; evt_in = 1'b0; evt_inv = 1'b0; evt_en = 1'b1;
        action = 3'd4; cap_en = 2'b11; rule0 = 2'd0; rule1 = 2'd0;
        flag_clr = 3'b000;
        repeat (3) @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 cap0", int'(cap0), 0);
        chk("R1 cap1", int'(cap1), 0);
        chk("R1 flags", int'({err_flag, cap_flag}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_timestamp();
        int s1;
        int c1;
        apply_reset();
        action = 3'd4;
        pulse(2, 5);
        s1 = int'(cap0);
        chk("R10 ch0 flag after stamp", int'(cap_flag), 1);
        pulse(3, 4);
        chk("R3 stamp spacing", int'(cap0) - s1, 7);
        chk("R10 error on overrun", int'(err_flag), 1);
        c1 = int'(count);
        @(negedge clk);
        chk("R3 free running", int'(count), c1 + 1);
    endtask

    task automatic t_per_w();
        apply_reset();
        action = 3'd5;
        pulse(3, 4);
        chk("R7 first edge stores no period", int'(cap_flag[0]), 0);
        chk("R4 width into ch1", int'(cap1), 3);
        pulse(5, 2);
        chk("R4 period into ch0", int'(cap0), 7);
        chk("R4 second width ch1", int'(cap1), 5);
    endtask

    task automatic t_w_per();
        apply_reset();
        action = 3'd6;
        pulse(2, 6);
        pulse(4, 1);
        chk("R5 period into ch1", int'(cap1), 8);
        chk("R5 width into ch0", int'(cap0), 4);
    endtask

    task automatic t_width_and_clear();
        apply_reset();
        action = 3'd7;
        pulse(6, 3);
        pulse(2, 2);
        chk("R6 width ch0", int'(cap0), 2);
        chk("R6 ch1 untouched", int'(cap1), 0);
        chk("R6 ch1 flag low", int'(cap_flag[1]), 0);
        chk("R10 overrun error", int'(err_flag), 1);
        clear(3'b001);
        chk("R11 ch0 flag cleared", int'(cap_flag[0]), 0);
        chk("R11 error kept", int'(err_flag), 1);
        clear(3'b100);
        chk("R11 error cleared", int'(err_flag), 0);
    endtask

    task automatic t_idle_codes();
        apply_reset();
        action = 3'd2;
        pulse(3, 3);
        action = 3'd0;
        pulse(2, 2);
        chk("R7 no capture in idle codes", int'({err_flag, cap_flag}), 0);
        chk("R7 ch0 value idle", int'(cap0), 0);
    endtask

    task automatic t_invert();
        apply_reset();
        evt_inv = 1'b1; evt_in = 1'b1;
        @(negedge clk);
        action = 3'd7;
        pulse(4, 3);
        chk("R2 inverted width", int'(cap0), 4);
    endtask

    task automatic t_gate();
        apply_reset();
        evt_en = 1'b0;
        action = 3'd7;
        pulse(3, 3);
        pulse(2, 2);
        chk("R2 gated no flag", int'(cap_flag), 0);
        chk("R2 gated no value", int'(cap0), 0);
    endtask

    task automatic t_enable();
        apply_reset();
        cap_en = 2'b10;
        action = 3'd7;
        pulse(5, 2);
        chk("R8 disabled value", int'(cap0), 0);
        chk("R8 disabled flag", int'(cap_flag), 0);
    endtask

    task automatic t_rules();
        apply_reset();
        rule0 = 2'd1;
        action = 3'd7;
        pulse(5, 2); pulse(3, 2); pulse(6, 2);
        chk("R9 min rule", int'(cap0), 3);
        apply_reset();
        rule1 = 2'd2;
        action = 3'd5;
        pulse(4, 2); pulse(2, 2); pulse(3, 2);
        chk("R9 max rule", int'(cap1), 4);
        apply_reset();
        rule0 = 2'd3;
        action = 3'd7;
        pulse(5, 2); pulse(7, 2); pulse(2, 2);
        chk("R9 reserved rule stores always", int'(cap0), 2);
    endtask

    initial begin
        rst_n = 1'b0; evt_in = 1'b0; evt_inv = 1'b0; evt_en = 1'b1;
        action = 3'd0; cap_en = 2'b11; rule0 = 2'd0; rule1 = 2'd0;
        flag_clr = 3'b000;
        t_reset();
        t_timestamp();
        t_per_w();
        t_w_per();
        t_width_and_clear();
        t_idle_codes();
        t_invert();
        t_gate();
        t_enable();
        t_rules();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule